// File: doc/BRIEF.md
# Control Register Write Side-Effect Unit

This block holds the processor's paging-control register, page-table base register, paging-feature register and extended feature register. It applies the side effects that writing them implies. Software-visible state goes in through one write port made of an enable, a register index and a data word. Every write is accepted in the cycle it is presented. There is no ready signal and no back-pressure, so the producer may write on every clock. State comes out through a combinational read port made of an index and a data word.

The unit compares each write with the stored value using XOR. Only bits that actually change can start a long-mode transition or a translation-buffer flush. Flush requests go out as one-cycle pulses to the instruction and data translation buffers, with separate flush-all and flush-non-global classes. A mode-recompute strobe tells the decoder to re-derive its operating mode. The unit also holds a time-stamp counter. It is stored as an offset from a free-running cycle counter, so the counter never needs a write path of its own.

Top module: `ctrl_reg_effects`

## Requirements
- R1: After reset, the read port returns 0x10 for the paging-control register (index 0) and zero for indices 1, 2, 3 and 5. All flush outputs and the recompute strobe are low.
- R2: Bit 4 of the paging-control register always reads as 1, whatever value was last written to it.
- R3: A write to index 0 that changes bit 31 (paging enable) sets long_mode_active to the new bit 31 when bit 8 of the extended feature register (index 3) is set. When bit 8 is clear, such a write leaves long_mode_active unchanged.
- R4: A write to index 0 that changes bit 31 raises flush-all to both translation buffers in the next cycle. A write that leaves bit 31 unchanged raises no flush.
- R5: Every write to index 1 raises flush-non-global to both buffers in the next cycle, even when the value written equals the stored value.
- R6: A write to index 2 raises flush-all in the next cycle exactly when it changes bit 4, 5 or 7. Changes confined to other bits raise nothing.
- R7: Writing V to index 4 makes index 4 read V+1 in the following cycle. The value then rises by one per clock, modulo 2^DATA_W.
- R8: The recompute strobe is high in the cycle after a write to index 0 or index 5, and low after writes to other indices.
- R9: Data written to index 5 is discarded. Index 5 reads {long_mode_active, paging enable, protection enable} in bits 2:0, with zeros above.
- R10: A write to index 3 stores the data, except bit 10 (long mode active), which keeps its previous value.
- R11: Each flush pulse and the recompute strobe stay high for exactly one cycle per causing write.
- R12: Writes to indices 6 and 7 change no register and raise no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, accepted every cycle |
| wr_idx | input | 3 | Register index of the write |
| wr_data | input | DATA_W | Write data |
| rd_idx | input | 3 | Register index of the read |
| rd_data | output | DATA_W | Read data, combinational |
| itlb_flush_all | output | 1 | Flush all entries, instruction buffer |
| dtlb_flush_all | output | 1 | Flush all entries, data buffer |
| itlb_flush_nonglobal | output | 1 | Flush non-global entries, instruction buffer |
| dtlb_flush_nonglobal | output | 1 | Flush non-global entries, data buffer |
| mode_recompute | output | 1 | Decoder mode recompute strobe |
| long_mode_active | output | 1 | Long-mode-active bit |

## Verification
The properties assume that wr_en is low while reset is asserted. They also assume that wr_idx and wr_data carry known values whenever wr_en is high. Under those conditions a past-cycle cause can be matched to every pulse. The bench drives every input at the falling edge, holds wr_en low through reset and releases it only from its write task. Its sweeps use every paging-enable, long-mode-enable and protection-enable combination and all 256 low paging-feature values, in sequence.

// File: rtl/cre_pkg.sv
package cre_pkg;
  localparam int IDX_W = 3;

  localparam logic [IDX_W-1:0] SEL_PGCTL = 3'd0;
  localparam logic [IDX_W-1:0] SEL_PTBASE = 3'd1;
  localparam logic [IDX_W-1:0] SEL_PGFEAT = 3'd2;
  localparam logic [IDX_W-1:0] SEL_EXTFEAT = 3'd3;
  localparam logic [IDX_W-1:0] SEL_STAMP = 3'd4;
  localparam logic [IDX_W-1:0] SEL_MODE = 3'd5;

  // bit positions in the paging-control register
  localparam int PE_BIT = 0;
  localparam int ET_BIT = 4;
  localparam int PG_BIT = 31;
  // bit positions in the paging-feature register
  localparam int PSE_BIT = 4;
  localparam int PAE_BIT = 5;
  localparam int PGE_BIT = 7;
  // bit positions in the extended feature register
  localparam int LME_BIT = 8;
  localparam int LMA_BIT = 10;

  // event vector layout
  localparam int EV_ALL = 0;
  localparam int EV_NG = 1;
  localparam int EV_RECOMP = 2;
  localparam int EV_N = 3;
endpackage

// File: rtl/cre_ctrl_regs.sv
module cre_ctrl_regs
  import cre_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] pgctl_q,
  output logic [DATA_W-1:0] ptbase_q,
  output logic [DATA_W-1:0] pgfeat_q,
  output logic [DATA_W-1:0] extfeat_q,
  output logic [EV_N-1:0]   events
);
  localparam logic [DATA_W-1:0] ET_MASK = DATA_W'(1) << ET_BIT;
  localparam logic [DATA_W-1:0] LMA_MASK = DATA_W'(1) << LMA_BIT;
  localparam logic [DATA_W-1:0] FEAT_FLUSH_MASK =
    (DATA_W'(1) << PSE_BIT) | (DATA_W'(1) << PAE_BIT) | (DATA_W'(1) << PGE_BIT);

  logic wr_pgctl, wr_ptbase, wr_pgfeat, wr_extfeat, wr_mode;
  logic [DATA_W-1:0] pgctl_diff, pgfeat_diff;
  logic pg_changed, feat_changed;

  always_comb begin
    wr_pgctl   = wr_en && (wr_idx == SEL_PGCTL);
    wr_ptbase  = wr_en && (wr_idx == SEL_PTBASE);
    wr_pgfeat  = wr_en && (wr_idx == SEL_PGFEAT);
    wr_extfeat = wr_en && (wr_idx == SEL_EXTFEAT);
    wr_mode    = wr_en && (wr_idx == SEL_MODE);
    pgctl_diff  = pgctl_q ^ wr_data;
    pgfeat_diff = pgfeat_q ^ wr_data;
    pg_changed   = pgctl_diff[PG_BIT];
    feat_changed = |(pgfeat_diff & FEAT_FLUSH_MASK);
    events = '0;
    events[EV_ALL]    = (wr_pgctl && pg_changed) || (wr_pgfeat && feat_changed);
    events[EV_NG]     = wr_ptbase;
    events[EV_RECOMP] = wr_pgctl || wr_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgctl_q   <= ET_MASK;
      ptbase_q  <= '0;
      pgfeat_q  <= '0;
      extfeat_q <= '0;
    end else begin
      if (wr_pgctl) begin
        pgctl_q <= wr_data | ET_MASK;
        if (pg_changed && extfeat_q[LME_BIT])
          extfeat_q[LMA_BIT] <= wr_data[PG_BIT];
      end
      if (wr_ptbase) ptbase_q <= wr_data;
      if (wr_pgfeat) pgfeat_q <= wr_data;
      if (wr_extfeat)
        extfeat_q <= (wr_data & ~LMA_MASK) | (extfeat_q & LMA_MASK);
    end
  end
endmodule

// File: rtl/cre_pulse_gen.sv
module cre_pulse_gen #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  output logic [N-1:0] pulse
);
  for (genvar g = 0; g < N; g++) begin : g_pulse
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse[g] <= 1'b0;
      else        pulse[g] <= ev[g];
    end
  end
endmodule

// File: rtl/cre_stamp.sv
module cre_stamp #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] stamp
);
  logic [W-1:0] cycles_q;
  logic [W-1:0] offset_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycles_q <= '0;
      offset_q <= '0;
    end else begin
      cycles_q <= cycles_q + W'(1);
      if (load) offset_q <= load_val - cycles_q;
    end
  end

  assign stamp = offset_q + cycles_q;
endmodule

// File: rtl/ctrl_reg_effects.sv
module ctrl_reg_effects
  import cre_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              itlb_flush_all,
  output logic              dtlb_flush_all,
  output logic              itlb_flush_nonglobal,
  output logic              dtlb_flush_nonglobal,
  output logic              mode_recompute,
  output logic              long_mode_active
);
  logic [DATA_W-1:0] pgctl_q, ptbase_q, pgfeat_q, extfeat_q, stamp;
  logic [EV_N-1:0] events, pulses;
  logic [DATA_W-1:0] mode_word;
  logic lme_bit, pg_bit;

  cre_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .pgctl_q(pgctl_q), .ptbase_q(ptbase_q),
    .pgfeat_q(pgfeat_q), .extfeat_q(extfeat_q), .events(events)
  );

  cre_pulse_gen #(.N(EV_N)) u_pulse (
    .clk(clk), .rst_n(rst_n), .ev(events), .pulse(pulses)
  );

  cre_stamp #(.W(DATA_W)) u_stamp (
    .clk(clk), .rst_n(rst_n),
    .load(wr_en && (wr_idx == SEL_STAMP)),
    .load_val(wr_data), .stamp(stamp)
  );

  assign itlb_flush_all       = pulses[EV_ALL];
  assign dtlb_flush_all       = pulses[EV_ALL];
  assign itlb_flush_nonglobal = pulses[EV_NG];
  assign dtlb_flush_nonglobal = pulses[EV_NG];
  assign mode_recompute       = pulses[EV_RECOMP];
  assign long_mode_active     = extfeat_q[LMA_BIT];
  assign lme_bit              = extfeat_q[LME_BIT];
  assign pg_bit               = pgctl_q[PG_BIT];

  always_comb begin
    mode_word = '0;
    mode_word[2:0] = {extfeat_q[LMA_BIT], pgctl_q[PG_BIT], pgctl_q[PE_BIT]};
    case (rd_idx)
      SEL_PGCTL:   rd_data = pgctl_q;
      SEL_PTBASE:  rd_data = ptbase_q;
      SEL_PGFEAT:  rd_data = pgfeat_q;
      SEL_EXTFEAT: rd_data = extfeat_q;
      SEL_STAMP:   rd_data = stamp;
      SEL_MODE:    rd_data = mode_word;
      default:     rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cre_chk.sv
module cre_chk
  import cre_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [2:0]        rd_idx,
  input logic [DATA_W-1:0] rd_data,
  input logic              itlb_flush_all,
  input logic              dtlb_flush_all,
  input logic              itlb_flush_nonglobal,
  input logic              dtlb_flush_nonglobal,
  input logic              mode_recompute,
  input logic              long_mode_active,
  input logic              lme_bit,
  input logic              pg_bit
);
  // R2
  et_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx == SEL_PGCTL |-> rd_data[ET_BIT]);
  // R3
  lma_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == SEL_PGCTL && lme_bit && (wr_data[PG_BIT] != pg_bit))
      |=> long_mode_active == $past(wr_data[PG_BIT]));
  // R4
  flush_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (itlb_flush_all == dtlb_flush_all) &&
    (itlb_flush_nonglobal == dtlb_flush_nonglobal));
  // R5
  ptbase_ng_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == SEL_PTBASE) |=> itlb_flush_nonglobal);
  // R6
  all_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    itlb_flush_all |-> $past(wr_en && (wr_idx == SEL_PGCTL || wr_idx == SEL_PGFEAT)));
  // R8
  recomp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx == SEL_PGCTL || wr_idx == SEL_MODE)) |=> mode_recompute);
  // R11
  ng_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    itlb_flush_nonglobal |-> $past(wr_en && wr_idx == SEL_PTBASE));
  // R11
  recomp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_recompute |-> $past(wr_en && (wr_idx == SEL_PGCTL || wr_idx == SEL_MODE)));
endmodule

bind ctrl_reg_effects cre_chk #(.DATA_W(DATA_W)) u_cre_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .rd_idx(rd_idx), .rd_data(rd_data), .itlb_flush_all(itlb_flush_all),
  .dtlb_flush_all(dtlb_flush_all), .itlb_flush_nonglobal(itlb_flush_nonglobal),
  .dtlb_flush_nonglobal(dtlb_flush_nonglobal), .mode_recompute(mode_recompute),
  .long_mode_active(long_mode_active), .lme_bit(lme_bit), .pg_bit(pg_bit)
);

// File: tb/test_ctrl_reg_effects.sv
module test_ctrl_reg_effects;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0] rd_idx = '0;
  logic [DW-1:0] rd_data;
  logic ifa, dfa, ifn, dfn, recomp, lma;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] m_pgctl = 64'h10;
  logic [DW-1:0] m_ptbase = '0;
  logic [DW-1:0] m_pgfeat = '0;
  logic [DW-1:0] m_ext = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_reg_effects #(.DATA_W(DW)) i_ctrl_reg_effects (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .itlb_flush_all(ifa), .dtlb_flush_all(dfa),
    .itlb_flush_nonglobal(ifn), .dtlb_flush_nonglobal(dfn),
    .mode_recompute(recomp), .long_mode_active(lma)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] idx, input string req, input logic [DW-1:0] exp);
    rd_idx = idx;
    #1;
    chk(req, rd_data, exp);
  endtask

  // write lands on the next rising edge; results are seen at the falling edge after it
  task automatic wr(input logic [2:0] idx, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulses(input string req, input logic fa, input logic fn, input logic rc);
    chk(req, {61'd0, ifa, dfa, recomp}, {61'd0, fa, fa, rc});
    chk(req, {62'd0, ifn, dfn}, {62'd0, fn, fn});
  endtask

  task automatic quiet(input string req);
    @(negedge clk);
    pulses(req, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic wr_pgctl(input logic [DW-1:0] d);
    logic fl;
    fl = d[31] != m_pgctl[31];
    if (fl && m_ext[8]) m_ext[10] = d[31];
    m_pgctl = d | 64'h10;
    wr(3'd0, d);
    pulses("R4/R8 pgctl write", fl, 1'b0, 1'b1);
    chk("R3 long_mode_active", {63'd0, lma}, {63'd0, m_ext[10]});
    rd(3'd0, "R2 ET forced", m_pgctl);
    quiet("R11 pgctl pulse width");
  endtask

  task automatic wr_ext(input logic [DW-1:0] d);
    m_ext = (d & ~64'h400) | (m_ext & 64'h400);
    wr(3'd3, d);
    pulses("R8 ext write", 1'b0, 1'b0, 1'b0);
    rd(3'd3, "R10 ext readback", m_ext);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, "R1 pgctl reset", 64'h10);
    rd(3'd1, "R1 ptbase reset", 64'h0);
    rd(3'd2, "R1 pgfeat reset", 64'h0);
    rd(3'd3, "R1 ext reset", 64'h0);
    rd(3'd5, "R1 mode reset", 64'h0);
    pulses("R1 outputs reset", 1'b0, 1'b0, 1'b0);

    // R3/R4 sweep over LME, PE and PG transitions
    for (int lme = 0; lme < 2; lme++) begin
      wr_ext((64'(lme) << 8) | 64'h401);
      for (int op = 0; op < 2; op++)
        for (int np = 0; np < 2; np++)
          for (int pe = 0; pe < 2; pe++) begin
            wr_pgctl((64'(op) << 31) | 64'(pe) | 64'hA0);
            wr_pgctl((64'(np) << 31) | 64'(pe));
            rd(3'd5, "R9 mode word", {61'd0, m_ext[10], m_pgctl[31], m_pgctl[0]});
          end
    end
    // leave long mode active for the mode-word test
    wr_ext(64'h100);
    wr_pgctl(64'h0);
    wr_pgctl(64'h8000_0001);

    // R9 mode index discards data
    wr(3'd5, {DW{1'b1}});
    pulses("R8 mode write strobe", 1'b0, 1'b0, 1'b1);
    rd(3'd5, "R9 mode data discarded", {61'd0, m_ext[10], m_pgctl[31], m_pgctl[0]});
    rd(3'd0, "R9 pgctl untouched", m_pgctl);
    quiet("R11 mode pulse width");

    // R5 page-table base, including a repeated value
    for (int k = 0; k < 3; k++) begin
      logic [DW-1:0] v;
      v = (k == 2) ? 64'h1234_5000 : 64'h1234_5000 + 64'(k) * 64'h1000;
      if (k == 2) v = 64'h1234_6000;
      m_ptbase = v;
      wr(3'd1, v);
      pulses("R5 ptbase flush", 1'b0, 1'b1, 1'b0);
      rd(3'd1, "R5 ptbase readback", m_ptbase);
      quiet("R11 ptbase pulse width");
    end

    // R6 sweep of the low paging-feature byte
    for (int i = 0; i < 257; i++) begin
      logic [DW-1:0] v;
      logic fl;
      v = (i == 256) ? 64'h0 : 64'(i);
      fl = |((v ^ m_pgfeat) & 64'hB0);
      m_pgfeat = v;
      wr(3'd2, v);
      pulses("R6 pgfeat flush", fl, 1'b0, 1'b0);
    end
    rd(3'd2, "R6 pgfeat readback", m_pgfeat);

    // R7 time stamp
    for (int t = 0; t < 3; t++) begin
      logic [DW-1:0] v;
      v = (t == 0) ? 64'h1000 : (t == 1) ? {DW{1'b1}} : 64'h8000_0000_0000_0005;
      wr(3'd4, v);
      rd(3'd4, "R7 stamp after write", v + 64'd1);
      pulses("R7 stamp no pulses", 1'b0, 1'b0, 1'b0);
      repeat (5 + t) @(negedge clk);
      rd(3'd4, "R7 stamp advance", v + 64'd1 + 64'(5 + t));
    end

    // R12 unused indices
    for (int u = 6; u < 8; u++) begin
      wr(3'(u), {DW{1'b1}});
      pulses("R12 unused no pulses", 1'b0, 1'b0, 1'b0);
      rd(3'd0, "R12 pgctl kept", m_pgctl);
      rd(3'd1, "R12 ptbase kept", m_ptbase);
      rd(3'd2, "R12 pgfeat kept", m_pgfeat);
      rd(3'd3, "R12 ext kept", m_ext);
      chk("R12 lma kept", {63'd0, lma}, {63'd0, m_ext[10]});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule